// File: doc/BRIEF.md
# Line Activation Controller

This block sequences the activation and deactivation of a four-wire subscriber line interface. A host issues single-cycle commands (power up, power down, activate, deactivate, force INFO 2). A mode input selects network-side (NT) or terminal-side (TE) behaviour. A receive front end reports which line signal it currently recognises, as an abstract INFO level. In return the block selects the INFO level to transmit, gates the analog circuitry and the line-signal detector, and enables bearer (2B+D) transfer once the loop is up. It also emits single-cycle events when activation completes, when the line deactivates, and when a forced-INFO 2 maintenance loop still sees the far end.

In NT mode, activation answers INFO 3 with INFO 4. A maintenance state lets a running NT fall back to sending INFO 2 without losing loop synchronisation, and only a fresh activation request leaves that state. In TE mode, the block walks INFO 1, then INFO 3 once INFO 2 arrives, and reports activation when INFO 4 is seen. Power-down is immediate and skips the release sequence.

Top module: `line_activation_ctrl`

## Requirements
- R1: After reset the block is powered down: tx_info = 0, analog_en = 0, lsd_en = 1, and bd_en, line_sync, act_done, deact_evt and pend_evt are all 0.
- R2: Command code 0 (power up), with cmd_valid high, takes the block from any state to the idle state on the next edge: analog_en = 1, lsd_en = 0, tx_info = 0, bd_en = 0. No deactivation event is raised.
- R3: Command code 1 (power down) takes the block from any state to the powered-down state on the next edge: analog_en = 0, lsd_en = 1, tx_info = 0. No deactivation event is raised.
- R4: In NT mode (mode_nt = 1), command code 2 (activate) from idle sets tx_info = 2. Receiving rx_info = 3 then sets tx_info = 4, bd_en = 1 and line_sync = 1, and pulses act_done for exactly one cycle.
- R5: In TE mode (mode_nt = 0), command code 2 from idle sets tx_info = 1. rx_info = 2 then sets tx_info = 3. rx_info = 4 then pulses act_done for one cycle and sets bd_en = 1, with tx_info staying 3.
- R6: Command code 3 (deactivate) is accepted only while mode_nt = 1 and an NT activation is pending, active or forced. It sets tx_info = 0 and bd_en = 0. A following rx_info = 0 returns the block to idle and pulses deact_evt. In TE mode the code is ignored.
- R7: Command code 4 (force INFO 2) is accepted only in NT mode while fully active. It sets tx_info = 2 and bd_en = 0 and keeps line_sync = 1. In any other case it is ignored.
- R8: While forced, the first cycle that sees rx_info = 3 pulses pend_evt for one cycle. There is one pulse per entry into the forced state.
- R9: Command code 2 in the forced state restores tx_info = 4 and bd_en = 1 and pulses act_done.
- R10: rx_info = 0 while active or forced (in either mode) returns the block to idle with tx_info = 0 and bd_en = 0, and pulses deact_evt.
- R11: While powered down, every command except power up is ignored. Activate is ignored outside idle and the forced state. Codes 5 to 7 are ignored.
- R12: An accepted command takes precedence over the receive level in the same cycle. An ignored command leaves the receive level in control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command: 0 up, 1 down, 2 activate, 3 deactivate, 4 force INFO 2 |
| mode_nt | input | 1 | 1 = NT behaviour, 0 = TE behaviour |
| rx_info | input | 3 | Received level 0 to 4; 5 to 7 mean nothing recognised |
| tx_info | output | 3 | INFO level to transmit |
| analog_en | output | 1 | Analog circuitry enable |
| lsd_en | output | 1 | Line-signal detector enable (active while powered down) |
| bd_en | output | 1 | Bearer 2B+D transfer enable |
| line_sync | output | 1 | Loop synchronisation held |
| act_done | output | 1 | One-cycle activation-complete event |
| deact_evt | output | 1 | One-cycle deactivation event |
| pend_evt | output | 1 | One-cycle event: forced state still receiving INFO 3 |

## Verification
Every output is a registered function of the sequencer state, so a wrong state shows at the ports one edge after the faulty transition. It appears as a wrong tx_info level or enable, or as a missing or extra event pulse. The bench keeps an independent behavioural model, compares all ports after every clock edge, and so localises a fault to its cycle. Directed sequences target the mode gating of commands, command-versus-receive precedence, and the one-shot nature of the pending event.

// File: rtl/line_activation_ctrl.sv
module line_activation_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       mode_nt,
  input  logic [2:0] rx_info,
  output logic [2:0] tx_info,
  output logic       analog_en,
  output logic       lsd_en,
  output logic       bd_en,
  output logic       line_sync,
  output logic       act_done,
  output logic       deact_evt,
  output logic       pend_evt
);

  localparam logic [2:0] CMD_UP    = 3'd0;
  localparam logic [2:0] CMD_DOWN  = 3'd1;
  localparam logic [2:0] CMD_ACT   = 3'd2;
  localparam logic [2:0] CMD_REL   = 3'd3;
  localparam logic [2:0] CMD_FORCE = 3'd4;

  typedef enum logic [3:0] {
    ST_OFF, ST_IDLE, ST_NT_I2, ST_NT_ACT, ST_NT_F2, ST_NT_REL,
    ST_TE_I1, ST_TE_I3, ST_TE_ACT
  } st_t;

  st_t  state, nxt;
  logic pend_seen;

  wire c_up    = cmd_valid && cmd_code == CMD_UP;
  wire c_down  = cmd_valid && cmd_code == CMD_DOWN;
  wire c_act   = cmd_valid && cmd_code == CMD_ACT;
  wire c_rel   = cmd_valid && cmd_code == CMD_REL;
  wire c_force = cmd_valid && cmd_code == CMD_FORCE;

  wire nt_live = state inside {ST_NT_I2, ST_NT_ACT, ST_NT_F2};
  wire up_now  = state inside {ST_NT_ACT, ST_NT_F2, ST_TE_ACT};

  always_comb begin
    nxt = state;
    if (c_down)
      nxt = ST_OFF;
    else if (c_up)
      nxt = ST_IDLE;
    else if (state != ST_OFF) begin
      if (c_act && state == ST_IDLE)
        nxt = mode_nt ? ST_NT_I2 : ST_TE_I1;
      else if (c_act && state == ST_NT_F2)
        nxt = ST_NT_ACT;
      else if (c_rel && mode_nt && nt_live)
        nxt = ST_NT_REL;
      else if (c_force && mode_nt && state == ST_NT_ACT)
        nxt = ST_NT_F2;
      else begin
        case (state)
          ST_NT_I2:  if (rx_info == 3'd3) nxt = ST_NT_ACT;
          ST_NT_ACT,
          ST_NT_F2,
          ST_TE_ACT,
          ST_NT_REL: if (rx_info == 3'd0) nxt = ST_IDLE;
          ST_TE_I1:  if (rx_info == 3'd2) nxt = ST_TE_I3;
          ST_TE_I3:  if (rx_info == 3'd4) nxt = ST_TE_ACT;
          default:   nxt = state;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      pend_seen <= 1'b0;
      act_done  <= 1'b0;
      deact_evt <= 1'b0;
      pend_evt  <= 1'b0;
    end else begin
      state     <= nxt;
      act_done  <= (nxt == ST_NT_ACT || nxt == ST_TE_ACT) && nxt != state;
      deact_evt <= nxt == ST_IDLE && !c_up && (up_now || state == ST_NT_REL);
      pend_evt  <= nxt == ST_NT_F2 && rx_info == 3'd3 && !pend_seen;
      pend_seen <= nxt == ST_NT_F2 && (pend_seen || rx_info == 3'd3);
    end
  end

  always_comb begin
    case (state)
      ST_NT_I2, ST_NT_F2:  tx_info = 3'd2;
      ST_NT_ACT:           tx_info = 3'd4;
      ST_TE_I1:            tx_info = 3'd1;
      ST_TE_I3, ST_TE_ACT: tx_info = 3'd3;
      default:             tx_info = 3'd0;
    endcase
  end

  assign analog_en = state != ST_OFF;
  assign lsd_en    = state == ST_OFF;
  assign bd_en     = state == ST_NT_ACT || state == ST_TE_ACT;
  assign line_sync = up_now;

  assert_up_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_up && !c_down) |=> (analog_en && !lsd_en && tx_info == 3'd0 && !deact_evt));

  assert_down_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_down |=> (!analog_en && lsd_en && tx_info == 3'd0 && !deact_evt && !bd_en));

  assert_act_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_done |-> (bd_en && line_sync) ##1 !act_done);

  assert_bearer_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bd_en |-> (tx_info == 3'd4 || tx_info == 3'd3));

  assert_force_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_force && mode_nt && tx_info == 3'd4) |=> (tx_info == 3'd2 && !bd_en && line_sync));

  assert_pend_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_evt |-> (tx_info == 3'd2 && line_sync) ##1 !pend_evt);

  assert_deact_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deact_evt |-> (tx_info == 3'd0 && analog_en && !bd_en && !line_sync));

  assert_off_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!analog_en && !c_up) |=> !analog_en);

endmodule

// File: tb/sim_line_activation_ctrl.sv
module sim_line_activation_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd7;
  logic mode_nt = 1'b1;
  logic [2:0] rx_info = 3'd7;
  logic [2:0] tx_info;
  logic analog_en, lsd_en, bd_en, line_sync, act_done, deact_evt, pend_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  line_activation_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mode_nt(mode_nt), .rx_info(rx_info), .tx_info(tx_info),
    .analog_en(analog_en), .lsd_en(lsd_en), .bd_en(bd_en),
    .line_sync(line_sync), .act_done(act_done), .deact_evt(deact_evt),
    .pend_evt(pend_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: powered flag, side, progress stage
  // stage: 0 idle, 1 first step, 2 TE second step, 3 active, 4 forced, 5 releasing
  bit m_pow = 0, m_nt = 0, m_seen = 0;
  int m_stage = 0;
  bit e_act = 0, e_deact = 0, e_pend = 0;

  function automatic int exp_tx();
    if (!m_pow) return 0;
    if (m_nt) begin
      if (m_stage == 1 || m_stage == 4) return 2;
      if (m_stage == 3) return 4;
      return 0;
    end
    if (m_stage == 1) return 1;
    if (m_stage == 2 || m_stage == 3) return 3;
    return 0;
  endfunction

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_pow = 0; m_stage = 0; m_seen = 0; e_act = 0; e_deact = 0; e_pend = 0;
    end else begin
      bit took;
      int was;
      took = 0; e_act = 0; e_deact = 0; e_pend = 0;
      was = m_stage;
      if (cmd_valid && cmd_code == 3'd1) begin m_pow = 0; m_stage = 0; end
      else if (cmd_valid && cmd_code == 3'd0) begin m_pow = 1; m_stage = 0; end
      else if (m_pow) begin
        if (cmd_valid && cmd_code == 3'd2 && was == 0) begin
          m_nt = mode_nt; m_stage = 1; took = 1;
        end else if (cmd_valid && cmd_code == 3'd2 && was == 4) begin
          m_stage = 3; e_act = 1; took = 1;
        end else if (cmd_valid && cmd_code == 3'd3 && mode_nt && m_nt &&
                     (was == 1 || was == 3 || was == 4)) begin
          m_stage = 5; took = 1;
        end else if (cmd_valid && cmd_code == 3'd4 && mode_nt && m_nt && was == 3) begin
          m_stage = 4; took = 1;
        end
        if (!took) begin
          if (m_nt && was == 1 && rx_info == 3'd3) begin m_stage = 3; e_act = 1; end
          else if (!m_nt && was == 1 && rx_info == 3'd2) m_stage = 2;
          else if (!m_nt && was == 2 && rx_info == 3'd4) begin m_stage = 3; e_act = 1; end
          else if ((was == 3 || was == 4 || was == 5) && rx_info == 3'd0) begin
            m_stage = 0; e_deact = 1;
          end
        end
      end
      if (m_pow && m_stage == 4) begin
        e_pend = (rx_info == 3'd3) && !m_seen;
        m_seen = m_seen || rx_info == 3'd3;
      end else m_seen = 0;
    end
    #(CLK_PERIOD/4);
    if (!finished) begin
      chk(tx_info == 3'(exp_tx()), "R4 tx_info", tx_info, exp_tx());
      chk(analog_en == m_pow, "R2 analog_en", analog_en, m_pow);
      chk(lsd_en == !m_pow, "R3 lsd_en", lsd_en, !m_pow);
      chk(bd_en == (m_pow && m_stage == 3), "R5 bd_en", bd_en, m_pow && m_stage == 3);
      chk(line_sync == (m_pow && (m_stage == 3 || m_stage == 4)), "R7 line_sync",
          line_sync, m_pow && (m_stage == 3 || m_stage == 4));
      chk(act_done == e_act, "R9 act_done", act_done, e_act);
      chk(deact_evt == e_deact, "R10 deact_evt", deact_evt, e_deact);
      chk(pend_evt == e_pend, "R8 pend_evt", pend_evt, e_pend);
    end
  end

  task automatic cyc(input bit v, input logic [2:0] c, input logic [2:0] r);
    @(negedge clk);
    cmd_valid = v; cmd_code = c; rx_info = r;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_info == 0 && !analog_en && lsd_en && !bd_en, "R1 reset", tx_info, 0);
    rst_n = 1'b1;
    cyc(0, 3'd7, 3'd7);
    chk(lsd_en && !act_done && !deact_evt && !pend_evt, "R1 idle after reset", lsd_en, 1);
    cyc(1, 3'd2, 3'd7);
    chk(!analog_en && tx_info == 0, "R11 activate while off", tx_info, 0);
    cyc(1, 3'd0, 3'd7);
    chk(analog_en && !lsd_en && tx_info == 0, "R2 power up", analog_en, 1);
    // NT sequence
    mode_nt = 1;
    cyc(1, 3'd2, 3'd7);
    chk(tx_info == 2, "R4 NT INFO 2", tx_info, 2);
    cyc(0, 3'd7, 3'd3);
    chk(tx_info == 4 && bd_en && act_done, "R4 NT active", tx_info, 4);
    cyc(0, 3'd7, 3'd3);
    chk(!act_done, "R4 one-cycle pulse", act_done, 0);
    cyc(1, 3'd2, 3'd3);
    chk(tx_info == 4 && !act_done, "R11 activate while active", tx_info, 4);
    cyc(1, 3'd6, 3'd3);
    chk(tx_info == 4 && bd_en, "R11 undefined code", tx_info, 4);
    cyc(1, 3'd4, 3'd3);
    chk(tx_info == 2 && !bd_en && line_sync, "R7 forced INFO 2", tx_info, 2);
    chk(pend_evt, "R8 pending event", pend_evt, 1);
    cyc(0, 3'd7, 3'd3);
    chk(!pend_evt && tx_info == 2, "R8 single pulse", pend_evt, 0);
    cyc(1, 3'd2, 3'd3);
    chk(tx_info == 4 && bd_en && act_done, "R9 restore", tx_info, 4);
    cyc(0, 3'd7, 3'd0);
    chk(tx_info == 0 && deact_evt && analog_en, "R10 lost line", tx_info, 0);
    // NT release sequence
    cyc(1, 3'd2, 3'd7);
    cyc(0, 3'd7, 3'd3);
    cyc(1, 3'd3, 3'd3);
    chk(tx_info == 0 && !bd_en && !deact_evt, "R6 release begins", tx_info, 0);
    cyc(0, 3'd7, 3'd3);
    chk(tx_info == 0 && !deact_evt, "R6 release waits", deact_evt, 0);
    cyc(0, 3'd7, 3'd0);
    chk(deact_evt, "R6 release done", deact_evt, 1);
    // precedence: release command beats received INFO 0
    cyc(1, 3'd2, 3'd7);
    cyc(0, 3'd7, 3'd3);
    cyc(1, 3'd3, 3'd0);
    chk(!deact_evt && tx_info == 0, "R12 command wins", deact_evt, 0);
    cyc(0, 3'd7, 3'd0);
    chk(deact_evt, "R12 then rx", deact_evt, 1);
    // ignored command lets rx act
    cyc(1, 3'd2, 3'd7);
    cyc(1, 3'd4, 3'd3);
    chk(tx_info == 4 && act_done, "R12 ignored cmd, rx acts", tx_info, 4);
    cyc(1, 3'd0, 3'd3);
    chk(tx_info == 0 && !deact_evt && analog_en, "R2 power up resets", deact_evt, 0);
    // TE sequence
    mode_nt = 0;
    cyc(1, 3'd2, 3'd0);
    chk(tx_info == 1, "R5 TE INFO 1", tx_info, 1);
    cyc(0, 3'd7, 3'd2);
    chk(tx_info == 3 && !bd_en, "R5 TE INFO 3", tx_info, 3);
    cyc(0, 3'd7, 3'd4);
    chk(act_done && bd_en && tx_info == 3, "R5 TE active", bd_en, 1);
    cyc(1, 3'd3, 3'd4);
    chk(bd_en && tx_info == 3, "R6 release ignored in TE", tx_info, 3);
    cyc(1, 3'd4, 3'd4);
    chk(bd_en && tx_info == 3, "R7 force ignored in TE", tx_info, 3);
    cyc(1, 3'd1, 3'd4);
    chk(!analog_en && lsd_en && tx_info == 0 && !deact_evt, "R3 power down", analog_en, 0);
    // random stream against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom_range(0, 5) == 0);
      cmd_code  = 3'($urandom_range(0, 7));
      rx_info   = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 40) == 0) mode_nt = ~mode_nt;
    end
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule